// File: doc/BRIEF.md
# DMA Address Table Walker

This block turns a device DMA address into a host address. It reads up to three levels of translation tables from memory: a region table, then a segment table, then a page table. Every entry is 64 bits wide. A root entry supplies the origin of the region table and a protection bit. The walker makes one 64-bit read per level over a single-outstanding request/response memory port. It reports the host address, the frame size as a power-of-two shift, a permission and an error code.

Before any read, the input address is checked against an inclusive lower and upper bound. A segment entry with its frame-control bit set ends the walk early with a 1 MiB frame. Protection bits seen along the way narrow the permission. Only one walk runs at a time. `busy` covers the whole walk, and `rspValid` pulses once with the result, which then stays on the outputs until the next walk finishes.

Entry layout for region and segment entries:
- bit 0: valid
- bits [3:2]: type, which is 3 for a region entry and 2 for a segment entry
- bits [5:4]: table offset
- bits [7:6]: table length
- bit 9: protect
- bit 10: frame control
- bits [63:12]: next-table origin

A page entry uses only bit 0 (valid), bit 9 (protect) and bits [63:12] (the frame address).

Top module: `dma_table_walker`

## Requirements
- R1: The walker aligns the input address down to 4 KiB. It reads region index bits [41:31], then segment index bits [30:20], then page index bits [19:12]. Each read goes to origin + index×8, with exactly one read per level visited. The region origin is bits [63:12] of `rootEntry`, and every deeper origin is bits [63:12] of the entry above it.
- R2: `rspShift` is 12 when the walk ends at a page entry, 20 when it ends at a segment entry, 31 when it ends at a region entry, and 12 on a range error.
- R3: An all-zero entry ends the walk with error code 2 and permission 2'b00.
- R4: A non-zero entry with bit 0 clear ends the walk with permission 2'b00. No table error is raised, so the result carries code 5 (nothing permitted).
- R5: A region entry whose length field is not 2'b11, or whose offset field is non-zero, ends the walk with code 3 and permission 2'b00.
- R6: A zero next-table origin ends the walk with code 4 and permission 2'b00. This includes a region entry whose type is not 3, a segment entry whose type is not 2, and a valid page entry with a zero frame address.
- R7: Permission starts at read-write (2'b11). Bit 9 of `rootEntry`, or bit 9 of any entry visited, narrows it to read-only (2'b01). A complete page walk returns the page frame address with code 0 when the access is allowed.
- R8: A valid segment entry of type 2 with bit 10 set completes the walk. The result is entry bits [63:20] joined with aligned input bits [19:0]. A walk that does not complete returns address 0.
- R9: An address below `lowBound` or above `highBound` returns code 1, permission 2'b00 and address 0, and makes no memory read. Both bounds are inclusive.
- R10: If there is no table error, a write to a read-only result, or any access to a result with permission 2'b00, returns code 5.
- R11: `busy` is high from the cycle after a request is accepted up to and including the single `rspValid` cycle. A request presented while `busy` is high, including in the `rspValid` cycle, is ignored.
- R12: After reset, `busy`, `memReq` and `rspValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk when idle |
| reqAddr | input | 64 | DMA address to translate |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| rootEntry | input | 64 | Region-table origin in [63:12], protect in bit 9 |
| lowBound | input | 64 | Lowest accepted address |
| highBound | input | 64 | Highest accepted address |
| busy | output | 1 | Walk in progress |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 64 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry read from memory |
| rspValid | output | 1 | One-cycle result pulse |
| rspAddr | output | 64 | Translated host address |
| rspPerm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rspShift | output | 6 | log2 of the frame size |
| rspErr | output | 3 | 0 ok, 1 range, 2 zero entry, 3 length, 4 type, 5 protection |

## Verification
Two of this block's functions can share a cycle: delivering a result and accepting the next request. The bench holds `reqValid` high with a second address from the cycle after the first acceptance, through the `rspValid` pulse. The first result must still match the first address. The second walk must start only in the idle cycle that follows, and its result must match the second address. A sweep over every combination of region, segment and page entry kinds, with both access types, both root protection settings and memory latencies of one to three cycles, also covers the case where a response arrives the cycle right after its request.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_RANGE  = 3'd1,
    ERR_ENTRY  = 3'd2,
    ERR_LENGTH = 3'd3,
    ERR_TYPE   = 3'd4,
    ERR_PROT   = 3'd5
  } walkErrT;

  typedef enum logic [1:0] {
    LVL_PAGE   = 2'd0,
    LVL_SEG    = 2'd1,
    LVL_REGION = 2'd2
  } walkLvlT;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b11;

  // Entry field positions
  localparam int F_VALID   = 0;
  localparam int F_TYPE_LO = 2;
  localparam int F_OFF_LO  = 4;
  localparam int F_LEN_LO  = 6;
  localparam int F_PROT    = 9;
  localparam int F_FC      = 10;

  typedef struct packed {
    logic start;  // latch request in idle
    logic take;   // evaluate the returned entry
  } walkStrobeT;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memRspValid,
  input  logic       rangeBad,
  input  logic       stepLast,
  output walkStrobeT strobe,
  output logic       busy,
  output logic       memReq,
  output logic       rspValid
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} stateT;
  stateT state, stateNext;

  always_comb begin
    strobe.start = (state == S_IDLE) && reqValid;
    strobe.take  = (state == S_WAIT) && memRspValid;
    stateNext    = state;
    case (state)
      S_IDLE:  if (reqValid) stateNext = rangeBad ? S_DONE : S_FETCH;
      S_FETCH: stateNext = S_WAIT;
      S_WAIT:  if (memRspValid) stateNext = stepLast ? S_DONE : S_FETCH;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy     = (state != S_IDLE);
  assign memReq   = (state == S_FETCH);
  assign rspValid = (state == S_DONE);

  a_r11_pulse_once: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r11_busy_at_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> busy);
  a_r1_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  a_r9_no_read_oor: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && rangeBad) |=> (rspValid && !memReq));
endmodule

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int PAGE_SHIFT   = 12,
  parameter int SEG_SHIFT    = 20,
  parameter int REGION_SHIFT = 31,
  parameter int IDX_W        = 11,
  parameter int PAGE_IDX_W   = 8,
  parameter int SHIFT_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobeT        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] rootEntry,
  input  logic [ADDR_W-1:0] lowBound,
  input  logic [ADDR_W-1:0] highBound,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rangeBad,
  output logic              stepLast,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [1:0]        rspPerm,
  output logic [SHIFT_W-1:0] rspShift,
  output logic [2:0]        rspErr
);
  localparam logic [ADDR_W-1:0] PAGE_LOW = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SEG_LOW  = (ADDR_W'(1) << SEG_SHIFT) - ADDR_W'(1);

  logic [ADDR_W-1:0] addrQ, originQ, idxOff, nextOrigin, resAddr, entry;
  logic              writeQ, typeOk, finish;
  logic [1:0]        permQ, nextPerm;
  walkLvlT           lvlQ;
  walkErrT           walkErr, finalErr;
  logic [SHIFT_W-1:0] lvlShift;

  assign entry    = memRspData;
  assign rangeBad = (reqAddr < lowBound) || (reqAddr > highBound);

  always_comb begin
    case (lvlQ)
      LVL_REGION: begin
        idxOff   = ADDR_W'(addrQ[REGION_SHIFT +: IDX_W]) << 3;
        typeOk   = (entry[F_TYPE_LO +: 2] == 2'b11);
        lvlShift = SHIFT_W'(REGION_SHIFT);
      end
      LVL_SEG: begin
        idxOff   = ADDR_W'(addrQ[SEG_SHIFT +: IDX_W]) << 3;
        typeOk   = (entry[F_TYPE_LO +: 2] == 2'b10);
        lvlShift = SHIFT_W'(SEG_SHIFT);
      end
      default: begin
        idxOff   = ADDR_W'(addrQ[PAGE_SHIFT +: PAGE_IDX_W]) << 3;
        typeOk   = 1'b1;
        lvlShift = SHIFT_W'(PAGE_SHIFT);
      end
    endcase
  end

  assign memAddr    = originQ + idxOff;
  assign nextOrigin = typeOk ? (entry & ~PAGE_LOW) : '0;

  // Evaluate the returned entry in priority order
  always_comb begin
    nextPerm = permQ;
    walkErr  = ERR_NONE;
    finish   = 1'b0;
    resAddr  = '0;
    if (entry == '0) begin
      walkErr  = ERR_ENTRY;
      nextPerm = PERM_NONE;
      finish   = 1'b1;
    end else if (!entry[F_VALID]) begin
      nextPerm = PERM_NONE;
      finish   = 1'b1;
    end else if (lvlQ == LVL_REGION &&
                 (entry[F_LEN_LO +: 2] != 2'b11 || entry[F_OFF_LO +: 2] != 2'b00)) begin
      walkErr  = ERR_LENGTH;
      nextPerm = PERM_NONE;
      finish   = 1'b1;
    end else if (nextOrigin == '0) begin
      walkErr  = ERR_TYPE;
      nextPerm = PERM_NONE;
      finish   = 1'b1;
    end else begin
      if (entry[F_PROT]) nextPerm = permQ & PERM_RO;
      if (lvlQ == LVL_PAGE) begin
        finish  = 1'b1;
        resAddr = nextOrigin;
      end else if (lvlQ == LVL_SEG && entry[F_FC]) begin
        finish  = 1'b1;
        resAddr = (entry & ~SEG_LOW) | (addrQ & SEG_LOW);
      end
    end
    if (walkErr != ERR_NONE) finalErr = walkErr;
    else if (nextPerm == PERM_NONE || (writeQ && nextPerm != PERM_RW)) finalErr = ERR_PROT;
    else finalErr = ERR_NONE;
  end

  assign stepLast = finish;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      originQ  <= '0;
      writeQ   <= 1'b0;
      permQ    <= PERM_NONE;
      lvlQ     <= LVL_REGION;
      rspAddr  <= '0;
      rspPerm  <= PERM_NONE;
      rspShift <= '0;
      rspErr   <= ERR_NONE;
    end else if (strobe.start) begin
      addrQ   <= reqAddr & ~PAGE_LOW;
      originQ <= rootEntry & ~PAGE_LOW;
      writeQ  <= reqWrite;
      lvlQ    <= LVL_REGION;
      permQ   <= rootEntry[F_PROT] ? PERM_RO : PERM_RW;
      if (rangeBad) begin
        rspAddr  <= '0;
        rspPerm  <= PERM_NONE;
        rspShift <= SHIFT_W'(PAGE_SHIFT);
        rspErr   <= ERR_RANGE;
      end
    end else if (strobe.take) begin
      if (finish) begin
        rspAddr  <= resAddr;
        rspPerm  <= nextPerm;
        rspShift <= lvlShift;
        rspErr   <= finalErr;
      end else begin
        originQ <= nextOrigin;
        permQ   <= nextPerm;
        lvlQ    <= walkLvlT'(lvlQ - 2'd1);
      end
    end
  end

  a_r3_zero_entry: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && memRspData == '0) |=> (rspErr == ERR_ENTRY && rspPerm == PERM_NONE));
  a_r9_range_code: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && rangeBad) |=> (rspErr == ERR_RANGE && rspAddr == '0));
  a_r7_perm_legal: assert property (@(posedge clk) disable iff (!rstN)
    rspPerm != 2'b10);
  a_r2_shift_legal: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && stepLast) |=> (rspShift == SHIFT_W'(PAGE_SHIFT) ||
      rspShift == SHIFT_W'(SEG_SHIFT) || rspShift == SHIFT_W'(REGION_SHIFT)));
endmodule

// File: rtl/dma_table_walker.sv
module dma_table_walker #(
  parameter int ADDR_W       = 64,
  parameter int PAGE_SHIFT   = 12,
  parameter int SEG_SHIFT    = 20,
  parameter int REGION_SHIFT = 31,
  parameter int IDX_W        = 11,
  parameter int PAGE_IDX_W   = 8,
  localparam int SHIFT_W     = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  rootEntry,
  input  logic [ADDR_W-1:0]  lowBound,
  input  logic [ADDR_W-1:0]  highBound,
  output logic               busy,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memRspValid,
  input  logic [ADDR_W-1:0]  memRspData,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [1:0]         rspPerm,
  output logic [SHIFT_W-1:0] rspShift,
  output logic [2:0]         rspErr
);
  walk_pkg::walkStrobeT strobe;
  logic rangeBad, stepLast;

  walk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .rangeBad(rangeBad), .stepLast(stepLast), .strobe(strobe),
    .busy(busy), .memReq(memReq), .rspValid(rspValid)
  );

  walk_dp #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SEG_SHIFT(SEG_SHIFT),
    .REGION_SHIFT(REGION_SHIFT), .IDX_W(IDX_W), .PAGE_IDX_W(PAGE_IDX_W),
    .SHIFT_W(SHIFT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .rootEntry(rootEntry), .lowBound(lowBound),
    .highBound(highBound), .memRspData(memRspData), .memAddr(memAddr),
    .rangeBad(rangeBad), .stepLast(stepLast), .rspAddr(rspAddr),
    .rspPerm(rspPerm), .rspShift(rspShift), .rspErr(rspErr)
  );
endmodule

// File: tb/sim_dma_table_walker.sv
`timescale 1ns/1ps
module sim_dma_table_walker;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [63:0] reqAddr, rootEntry, lowBound, highBound;
  logic        busy, memReq, memRspValid, rspValid;
  logic [63:0] memAddr, memRspData, rspAddr;
  logic [1:0]  rspPerm;
  logic [5:0]  rspShift;
  logic [2:0]  rspErr;

  int checks = 0;
  int errors = 0;
  int readCount = 0;
  int lat = 1;

  logic [63:0] mem [0:8191];

  always #2.5 clk = ~clk;

  dma_table_walker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .rootEntry(rootEntry), .lowBound(lowBound),
    .highBound(highBound), .busy(busy), .memReq(memReq), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rspValid(rspValid),
    .rspAddr(rspAddr), .rspPerm(rspPerm), .rspShift(rspShift), .rspErr(rspErr)
  );

  function automatic logic [63:0] memRd(input logic [63:0] a);
    if (a < 64'h10000) return mem[a[15:3]];
    return 64'h0;
  endfunction

  // Memory responder: fixed latency, one outstanding read
  logic        pend = 1'b0;
  logic [63:0] pendAddr;
  int          pendCnt;
  initial begin
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend) begin
        if (pendCnt <= 1) begin
          memRspValid = 1'b1;
          memRspData  = memRd(pendAddr);
          readCount++;
          pend = 1'b0;
        end else pendCnt--;
      end
      if (memReq) begin
        pend = 1'b1;
        pendAddr = memAddr;
        pendCnt = lat;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference walk written from the requirements
  task automatic model(input logic [63:0] a, input logic w, input logic [63:0] root,
                       output logic [63:0] eAddr, output logic [1:0] ePerm,
                       output logic [5:0] eShift, output logic [2:0] eErr,
                       output int eReads);
    logic [63:0] ag, org, e, nto, idx;
    bit done;
    eAddr = 0; ePerm = root[9] ? 2'b01 : 2'b11; eShift = 12; eErr = 0; eReads = 0;
    if (a < lowBound || a > highBound) begin
      ePerm = 0; eErr = 1; return;
    end
    ag = a & ~64'hFFF;
    org = root & ~64'hFFF;
    done = 0;
    for (int lvl = 2; lvl >= 0 && !done; lvl--) begin
      idx = (lvl == 2) ? ((ag >> 31) & 64'h7FF) :
            (lvl == 1) ? ((ag >> 20) & 64'h7FF) : ((ag >> 12) & 64'hFF);
      e = memRd(org + idx * 8);
      eReads++;
      eShift = (lvl == 2) ? 6'd31 : (lvl == 1) ? 6'd20 : 6'd12;
      if (lvl == 2)      nto = (e[3:2] == 2'b11) ? (e & ~64'hFFF) : 0;
      else if (lvl == 1) nto = (e[3:2] == 2'b10) ? (e & ~64'hFFF) : 0;
      else               nto = e & ~64'hFFF;
      done = 1;
      if (e == 0) begin eErr = 2; ePerm = 0; end
      else if (!e[0]) ePerm = 0;
      else if (lvl == 2 && (e[7:6] != 2'b11 || e[5:4] != 0)) begin eErr = 3; ePerm = 0; end
      else if (nto == 0) begin eErr = 4; ePerm = 0; end
      else begin
        if (e[9]) ePerm = ePerm & 2'b01;
        if (lvl == 0) eAddr = nto;
        else if (lvl == 1 && e[10]) eAddr = (e & ~64'hFFFFF) | (ag & 64'hFFFFF);
        else begin done = 0; org = nto; end
      end
    end
    if (eErr == 0 && (ePerm == 0 || (w && ePerm != 2'b11))) eErr = 5;
  endtask

  function automatic string tagFor(input logic [2:0] err, input logic [1:0] perm,
                                   input logic [5:0] shift);
    case (err)
      3'd1: return "R9";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return (perm == 2'b00) ? "R4" : "R10";
      default: return (shift == 6'd20) ? "R8" : "R7";
    endcase
  endfunction

  function automatic logic [63:0] regionKind(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h60CC;      // valid clear
      2: return 64'h604D;      // bad length
      3: return 64'h60DD;      // non-zero offset
      4: return 64'h60C9;      // wrong type
      5: return 64'h60CD;      // good
      default: return 64'h62CD; // good, protected
    endcase
  endfunction

  function automatic logic [63:0] segKind(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'hB008;
      2: return 64'hB00D;
      3: return 64'hB009;
      4: return 64'hB209;
      5: return 64'h0000_00AB_CDE0_0409;  // frame control
      6: return 64'h0000_00AB_CDE0_0609;  // frame control, protected
      default: return 64'h409;             // frame control, zero frame
    endcase
  endfunction

  function automatic logic [63:0] pageKind(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h0000_0077_8899_A000;
      2: return 64'h1;
      3: return 64'h0000_0077_8899_A001;
      default: return 64'h0000_0077_8899_A201;
    endcase
  endfunction

  task automatic setEntries(input logic [63:0] a, input int rk, input int sk, input int pk);
    mem[(64'h1000 + ((a >> 31) & 64'h7FF) * 8) >> 3] = regionKind(rk);
    mem[(64'h6000 + ((a >> 20) & 64'h7FF) * 8) >> 3] = segKind(sk);
    mem[(64'hB000 + ((a >> 12) & 64'hFF) * 8) >> 3] = pageKind(pk);
  endtask

  task automatic waitRsp(output bit ok);
    int cyc = 0;
    while (!rspValid && cyc < 300) begin @(negedge clk); cyc++; end
    ok = rspValid;
  endtask

  task automatic compare(input logic [63:0] eAddr, input logic [1:0] ePerm,
                         input logic [5:0] eShift, input logic [2:0] eErr);
    string t = tagFor(eErr, ePerm, eShift);
    check(rspErr == eErr, t, "error code", 64'(rspErr), 64'(eErr));
    check(rspPerm == ePerm, t, "permission", 64'(rspPerm), 64'(ePerm));
    check(rspAddr == eAddr, t, "address", rspAddr, eAddr);
    check(rspShift == eShift, "R2", "frame shift", 64'(rspShift), 64'(eShift));
  endtask

  task automatic runWalk(input logic [63:0] a, input logic w, input logic [63:0] root);
    logic [63:0] eAddr; logic [1:0] ePerm; logic [5:0] eShift; logic [2:0] eErr;
    int eReads; bit ok;
    model(a, w, root, eAddr, ePerm, eShift, eErr, eReads);
    @(negedge clk);
    readCount = 0;
    reqValid = 1'b1; reqAddr = a; reqWrite = w; rootEntry = root;
    @(negedge clk);
    reqValid = 1'b0;
    waitRsp(ok);
    check(ok, "R11", "result pulse seen", 64'(ok), 64'd1);
    compare(eAddr, ePerm, eShift, eErr);
    check(readCount == eReads, (eErr == 1) ? "R9" : "R1", "read count",
          64'(readCount), 64'(eReads));
    @(negedge clk);
    check(!busy && !rspValid, "R11", "idle after pulse", {62'd0, busy, rspValid}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] aA, aB, eAddr; logic [1:0] ePerm; logic [5:0] eShift; logic [2:0] eErr;
    int eReads, n; bit ok;
    for (int i = 0; i < 8192; i++) mem[i] = 64'h0;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0;
    rootEntry = 64'h1000; lowBound = 64'h0; highBound = '1;
    repeat (3) @(negedge clk);
    check(!busy && !memReq && !rspValid, "R12", "reset outputs",
          {61'd0, busy, memReq, rspValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq && !rspValid, "R12", "after reset release",
          {61'd0, busy, memReq, rspValid}, 64'd0);

    // Sweep over all entry-kind combinations
    n = 0;
    for (int rk = 0; rk < 7; rk++)
      for (int sk = 0; sk < 8; sk++)
        for (int pk = 0; pk < 5; pk++)
          for (int w = 0; w < 2; w++)
            for (int rp = 0; rp < 2; rp++) begin
              logic [63:0] a;
              a = (64'((n * 37 + 5) % 2048) << 31) | (64'((n * 53 + 3) % 2048) << 20) |
                  (64'((n * 11 + 1) % 256) << 12) | 64'((n * 97) % 4096);
              setEntries(a, rk, sk, pk);
              lat = 1 + (n % 3);
              runWalk(a, w[0], rp[0] ? 64'h1200 : 64'h1000);
              n++;
            end

    // Bounds, both sides, inclusive
    lowBound = 64'h1_0000_0000; highBound = 64'h2_0000_0000;
    setEntries(64'h1_0000_0000, 5, 3, 3);
    setEntries(64'h2_0000_0000, 5, 5, 0);
    runWalk(64'h0_FFFF_FFFF, 1'b0, 64'h1000);
    runWalk(64'h1_0000_0000, 1'b0, 64'h1000);
    runWalk(64'h2_0000_0000, 1'b0, 64'h1000);
    runWalk(64'h2_0000_0001, 1'b1, 64'h1000);
    runWalk(64'h0, 1'b0, 64'h1000);
    runWalk('1, 1'b0, 64'h1000);
    lowBound = 64'h0; highBound = '1;

    // Request held through the result pulse: ignored while busy
    lat = 2;
    aA = (64'd100 << 31) | (64'd200 << 20) | (64'd30 << 12) | 64'h123;
    aB = (64'd101 << 31) | (64'd201 << 20) | (64'd31 << 12) | 64'h456;
    setEntries(aA, 5, 3, 3);
    setEntries(aB, 6, 5, 0);
    model(aA, 1'b0, 64'h1000, eAddr, ePerm, eShift, eErr, eReads);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = aA; reqWrite = 1'b0; rootEntry = 64'h1000;
    @(negedge clk);
    reqAddr = aB;
    check(busy, "R11", "busy after accept", 64'(busy), 64'd1);
    waitRsp(ok);
    check(ok, "R11", "first pulse", 64'(ok), 64'd1);
    compare(eAddr, ePerm, eShift, eErr);
    @(negedge clk);
    check(!busy, "R11", "request in pulse cycle ignored", 64'(busy), 64'd0);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy, "R11", "accepted after idle cycle", 64'(busy), 64'd1);
    model(aB, 1'b0, 64'h1000, eAddr, ePerm, eShift, eErr, eReads);
    waitRsp(ok);
    check(ok, "R11", "second pulse", 64'(ok), 64'd1);
    compare(eAddr, ePerm, eShift, eErr);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule